// File: doc/BRIEF.md
# Two-Clock Shift-Register Latch Chain

This block is a chain of scannable storage cells. Each cell holds a master (first-rank) latch and a slave (second-rank) latch. Three level-sensitive clock controls decide what each cell does:

- The system clock loads functional data into the master latch.
- Scan clock A moves the previous cell's slave value into the master latch. For cell 0, the source is the serial chain input.
- Scan clock B copies each master latch into its slave latch.

A full scan shift is an A pulse followed by a B pulse, with the two never high together. A normal functional update is a system pulse followed by a B pulse.

The design samples the clock controls as levels on a fast free-running fabric clock `clk`. In each `clk` cycle, every control that is high acts once on the values held before that edge, so the result does not depend on the order in which inputs change. When the controls overlap in a forbidden way, an error flag rises and every latch keeps its value. Every cell's slave value comes out in parallel, and the last cell's slave value also drives the serial scan output.

Top module: `srl_chain`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every master and slave latch clears to 0, so `stage_q` and `scan_out` read 0 after that edge.
- R2: With only `shift_a` high, each master latch k takes the slave value of cell k-1, and master latch 0 takes `scan_in`. The slave latches keep their values.
- R3: With only `xfer_b` high, each slave latch takes the value its master latch held before the edge. The master latches keep their values.
- R4: With only `sys_c` high, master latch k takes `sys_d[k]` and the slave latches keep their values.
- R5: With all three clock controls low, every latch keeps its value.
- R6: When `shift_a` and `sys_c` are both high, or `shift_a` and `xfer_b` are both high, `clk_err` reads 1 in that same cycle (default build) and no latch changes. Otherwise `clk_err` reads 0.
- R7: With `sys_c` and `xfer_b` high together, the master latches take `sys_d` and the slave latches take the master values from before the edge, independent of order.
- R8: `stage_q[k]` is the slave latch of cell k, and `scan_out` equals `stage_q[STAGES-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the clock controls |
| rst | input | 1 | Synchronous reset, active high, applied with all controls low |
| sys_c | input | 1 | System clock level: load functional data into master latches |
| shift_a | input | 1 | Scan clock A level: load master latches from the chain |
| xfer_b | input | 1 | Scan clock B level: copy master into slave latches |
| scan_in | input | 1 | Serial chain input to cell 0 |
| sys_d | input | STAGES | Functional data, one bit per cell |
| stage_q | output | STAGES | Slave latch value of every cell |
| scan_out | output | 1 | Slave latch value of the last cell |
| clk_err | output | 1 | Forbidden clock overlap detected |

## Verification
The error flag depends only on the inputs present in the current cycle. The bench drives inputs just after a falling edge and compares `clk_err` one nanosecond later, before the next rising edge.

Latch contents change on the rising edge that samples the controls. The bench therefore compares `stage_q` and `scan_out` one nanosecond after that edge. The behavioural model advances at the same point, using the inputs that were present at the edge.

Because every cycle is compared, a value that shifts through the chain shows up one A/B pair per cell later at `scan_out`. A conflict cycle must show unchanged outputs immediately after its edge.

// File: rtl/srl_pkg.sv
package srl_pkg;
   // per-cell actions granted for one fabric cycle
   typedef struct packed {
      logic load_sys;
      logic load_scan;
      logic copy_slave;
   } srl_ctl_t;
endpackage

// File: rtl/srl_clock_guard.sv
module srl_clock_guard
   import srl_pkg::*;
#(
   parameter bit ERR_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     sys_c,
   input  logic     shift_a,
   input  logic     xfer_b,
   output srl_ctl_t ctl,
   output logic     clk_err
);
   logic conflict;

   always_comb begin
      conflict       = (shift_a & sys_c) | (shift_a & xfer_b);
      ctl.load_sys   = sys_c   & ~conflict;
      ctl.load_scan  = shift_a & ~conflict;
      ctl.copy_slave = xfer_b  & ~conflict;
   end

   generate
      if (ERR_REG) begin : g_err_reg
         logic err_q;
         always_ff @(posedge clk) begin
            if (rst) err_q <= 1'b0;
            else     err_q <= conflict;
         end
         assign clk_err = err_q;
      end else begin : g_err_comb
         assign clk_err = conflict;
      end
   endgenerate

   // R6: a granted scan load never coincides with another grant
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
      ctl.load_scan |-> !ctl.load_sys && !ctl.copy_slave);
   // R6: a raw A request paired with B yields no grant of A
   a_r6_grant_blocked: assert property (@(posedge clk) disable iff (rst)
      (shift_a && xfer_b) |-> !ctl.load_scan && !ctl.copy_slave);
endmodule

// File: rtl/srl_cell.sv
module srl_cell
   import srl_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  srl_ctl_t ctl,
   input  logic     d_sys,
   input  logic     d_scan,
   output logic     slave_q
);
   logic master_q;

   // master rank: system or scan source, never both (guard ensures)
   always_ff @(posedge clk) begin
      if (rst)                master_q <= 1'b0;
      else if (ctl.load_scan) master_q <= d_scan;
      else if (ctl.load_sys)  master_q <= d_sys;
   end

   // slave rank samples the master value held before the edge
   always_ff @(posedge clk) begin
      if (rst)                 slave_q <= 1'b0;
      else if (ctl.copy_slave) slave_q <= master_q;
   end

   a_r1_clear: assert property (@(posedge clk)
      rst |=> (master_q == 1'b0) && (slave_q == 1'b0));
   a_r2_scan_load: assert property (@(posedge clk) disable iff (rst)
      ctl.load_scan |=> master_q == $past(d_scan));
   a_r3_copy: assert property (@(posedge clk) disable iff (rst)
      ctl.copy_slave |=> slave_q == $past(master_q));
   a_r5_master_hold: assert property (@(posedge clk) disable iff (rst)
      (!ctl.load_scan && !ctl.load_sys) |=> $stable(master_q));
   a_r5_slave_hold: assert property (@(posedge clk) disable iff (rst)
      !ctl.copy_slave |=> $stable(slave_q));
endmodule

// File: rtl/srl_chain.sv
module srl_chain
   import srl_pkg::*;
#(
   parameter int STAGES  = 8,
   parameter bit ERR_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sys_c,
   input  logic              shift_a,
   input  logic              xfer_b,
   input  logic              scan_in,
   input  logic [STAGES-1:0] sys_d,
   output logic [STAGES-1:0] stage_q,
   output logic              scan_out,
   output logic              clk_err
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("srl_chain: STAGES must be at least 1");
      end
   endgenerate

   srl_ctl_t          ctl;
   logic [STAGES-1:0] scan_src;

   srl_clock_guard #(.ERR_REG(ERR_REG)) i_guard (
      .clk     (clk),
      .rst     (rst),
      .sys_c   (sys_c),
      .shift_a (shift_a),
      .xfer_b  (xfer_b),
      .ctl     (ctl),
      .clk_err (clk_err)
   );

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_cell
         if (k == 0) begin : g_head
            assign scan_src[k] = scan_in;
         end else begin : g_link
            assign scan_src[k] = stage_q[k-1];
         end
         srl_cell i_cell (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .d_sys   (sys_d[k]),
            .d_scan  (scan_src[k]),
            .slave_q (stage_q[k])
         );
      end
   endgenerate

   assign scan_out = stage_q[LAST];

   generate
      if (!ERR_REG) begin : g_err_checks
         // R6: a flagged cycle leaves the whole chain unchanged
         a_r6_hold_on_conflict: assert property (@(posedge clk) disable iff (rst)
            clk_err |=> $stable(stage_q));
      end
   endgenerate
   a_r8_tail: assert property (@(posedge clk) disable iff (rst)
      scan_out == stage_q[LAST]);
endmodule

// File: tb/test_srl_chain.sv
module test_srl_chain;
   localparam int N = 8;
   localparam time CLK_P = 4ns;

   logic clk = 1'b0;
   logic rst, sys_c, shift_a, xfer_b, scan_in;
   logic [N-1:0] sys_d;
   logic [N-1:0] stage_q;
   logic scan_out, clk_err;

   int total = 0;
   int bad = 0;
   logic [N-1:0] m1, m2;

   always #(CLK_P/2) clk = ~clk;

   srl_chain #(.STAGES(N)) i_srl_chain (
      .clk(clk), .rst(rst), .sys_c(sys_c), .shift_a(shift_a), .xfer_b(xfer_b),
      .scan_in(scan_in), .sys_d(sys_d), .stage_q(stage_q),
      .scan_out(scan_out), .clk_err(clk_err)
   );

   task automatic check_bits(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(string tag, logic c, logic a, logic b, logic si, logic [N-1:0] d);
      logic conflict;
      logic [N-1:0] n1, n2;
      @(negedge clk);
      sys_c = c; shift_a = a; xfer_b = b; scan_in = si; sys_d = d;
      #1;
      conflict = (a & c) | (a & b);
      check_bits({tag, " R6 clk_err"}, {{(N-1){1'b0}}, clk_err}, {{(N-1){1'b0}}, conflict});
      @(posedge clk);
      #1;
      n1 = m1; n2 = m2;
      if (!conflict) begin
         for (int k = 0; k < N; k++) begin
            if (c) n1[k] = d[k];
            if (a) n1[k] = (k == 0) ? si : m2[k-1];
            if (b) n2[k] = m1[k];
         end
      end
      m1 = n1; m2 = n2;
      check_bits({tag, " stage_q"}, stage_q, m2);
      check_bits({tag, " R8 scan_out"}, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m2[N-1]});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sys_c = 0; shift_a = 0; xfer_b = 0; scan_in = 0; sys_d = '0;
      @(posedge clk); @(posedge clk); #1;
      m1 = '0; m2 = '0;
      check_bits("R1 reset stage_q", stage_q, '0);
      check_bits("R1 reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);
      @(negedge clk); rst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [N-1:0] pat;
      rst = 1'b1; sys_c = 0; shift_a = 0; xfer_b = 0; scan_in = 0; sys_d = '0;
      do_reset();
      // R2/R3: shift a pattern through the chain with A then B pulses
      pat = 8'b1011_0010;
      for (int i = 0; i < N + 2; i++) begin
         step("R2 shift", 0, 1, 0, pat[i % N], '0);
         step("R3 copy", 0, 0, 1, 0, '0);
      end
      // R5: idle hold
      for (int i = 0; i < 3; i++) step("R5 idle", 0, 0, 0, 1, 8'hFF);
      // R4 then R3: functional update
      step("R4 sys load", 1, 0, 0, 0, 8'h5A);
      step("R3 copy after sys", 0, 0, 1, 0, 8'h00);
      // R6: forbidden overlaps hold everything
      step("R6 A with C", 1, 1, 0, 1, 8'hFF);
      step("R6 A with B", 0, 1, 1, 1, 8'hFF);
      step("R6 all high", 1, 1, 1, 0, 8'h00);
      // R7: C and B together
      step("R4 sys load", 1, 0, 0, 0, 8'hC3);
      step("R7 C with B", 1, 0, 1, 0, 8'h3C);
      step("R3 copy", 0, 0, 1, 0, 8'h00);
      // R1 again mid-run
      do_reset();
      // mixed stimulus
      for (int i = 0; i < 400; i++) begin
         logic [3:0] r;
         r = 4'($urandom_range(0, 15));
         step("R2 R3 R4 R7 mixed", r[0], r[1] & r[3], r[2], r[3], 8'($urandom));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule